// File: doc/BRIEF.md
# Burst PSRAM Configuration Register Controller

This block is the device-side control logic of a pseudo-static RAM that supports burst transfers. It holds the bus configuration word. The word is loaded by a control-register-set command, and the block decodes it into an operating mode and a read latency. From these it does two things. It times the first read data beat from the cycle in which the address-valid strobe is sampled. It also classifies each write as synchronous or asynchronous, depending on whether a rising clock edge sees the address strobe asserted during the write.

All control inputs are active high and are sampled on the rising edge of `clk`. A configuration command is an edge that samples `chip_sel`, `cfg_sel`, `wr_sel` and `addr_vld` all high, with `addr_in[19]` high. With bit 19 low, the command addresses a different register and this block does nothing. The configured word can be read at `cfg_word`. The memory array, refresh and the refresh configuration register belong to other blocks.

Top module: `burst_cfg_ctrl`

## Requirements
- R1: After reset, `cfg_word` is 21'h89840, `op_mode` is 0 (asynchronous), `rd_latency` is 3, and `cfg_err`, `wr_is_sync` and `first_beat` are all 0.
- R2: A configuration command with `addr_in[19]`=1 that arrives while idle loads the word from `addr_in`, and `cfg_word` shows the new value after that edge. A command with `addr_in[19]`=0 leaves `cfg_word` unchanged.
- R3: Whatever value is written, `cfg_word` bit 19 reads 1, bit 9 reads 0 and bit 6 reads 1.
- R4: Bit 15 of the word selects the mode. Bit 15 = 1 gives `op_mode` 0 (asynchronous). Bit 15 = 0 gives `op_mode` 1 (synchronous read, asynchronous write) when `wr_is_sync` is 0, and `op_mode` 2 (fully synchronous) when `wr_is_sync` is 1.
- R5: Bits 13:11 hold the latency code, and `rd_latency` equals the code. Only code 010 (2 cycles) and code 011 (3 cycles) are legal.
- R6: A command that carries any other latency code writes the remaining bits and keeps the old latency code. It also sets `cfg_err`, which stays at 1 until reset.
- R7: A read start is an edge k that samples `chip_sel` and `addr_vld` high and `wr_sel` and `cfg_sel` low, with bit 15 = 0. After a read start, `first_beat` is high for exactly the one cycle that follows edge k+L, where L is the latency at edge k. The pulse is gated by `out_en`, so no pulse appears while `out_en` is low.
- R8: An edge that samples `chip_sel` low ends the access and cancels any pending `first_beat`.
- R9: A configuration command is ignored while an access is in progress. An access is in progress from an edge that samples `chip_sel` and `addr_vld` high with `cfg_sel` low, until an edge that samples `chip_sel` low.
- R10: In a synchronous mode, a write edge (`chip_sel`, `wr_sel` high and `cfg_sel` low) that samples `addr_vld` high sets `wr_is_sync` to 1. A write edge with `addr_vld` low, before any such edge in the current access, sets `wr_is_sync` to 0.
- R11: In asynchronous mode, `first_beat` never pulses and `wr_is_sync` is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Power-on reset, active low |
| chip_sel | input | 1 | Device selected |
| addr_vld | input | 1 | Address-valid strobe |
| wr_sel | input | 1 | Write enable |
| out_en | input | 1 | Output enable |
| cfg_sel | input | 1 | Configuration register access select |
| addr_in | input | 21 | Address bus; carries the data of a configuration command |
| op_mode | output | 2 | 0 async, 1 sync read / async write, 2 full sync |
| rd_latency | output | 3 | Active read latency in cycles |
| first_beat | output | 1 | One-cycle pulse marking the first read data beat |
| wr_is_sync | output | 1 | Type of the most recent write classification |
| cfg_word | output | 21 | Current configuration word |
| cfg_err | output | 1 | Sticky flag: a reserved latency code was written |

## Verification
A corrupted configuration word shows up at `cfg_word` on the cycle after the command, and at `op_mode` and `rd_latency` as well. A latency counter that loads the wrong value, or that misses an abort, moves `first_beat` off the exact cycle k+L or makes it appear when none was expected. A busy flag that clears early lets a mid-burst command alter `cfg_word` one cycle later. A wrong edge-detection state flips `wr_is_sync`, and therefore `op_mode`, right after the edge of the write.

// File: rtl/burst_cfg_pkg.sv
package burst_cfg_pkg;

  localparam int LAT_W = 3;

  typedef enum logic [1:0] {
    MODE_ASYNC     = 2'd0,
    MODE_SYNC_RD   = 2'd1,
    MODE_FULL_SYNC = 2'd2
  } op_mode_e;

  // A latency code is usable only for the two defined burst latencies.
  function automatic logic lat_code_ok(input logic [LAT_W-1:0] code);
    return (code == LAT_W'(2)) || (code == LAT_W'(3));
  endfunction

  // Mode from the asynchronous select bit and the last write classification.
  function automatic op_mode_e decode_mode(input logic async_bit, input logic wsync);
    if (async_bit) return MODE_ASYNC;
    return wsync ? MODE_FULL_SYNC : MODE_SYNC_RD;
  endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_cfg_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int SEL_BIT  = 19,
  parameter int OPM_BIT  = 15,
  parameter int LAT_LSB  = 11,
  parameter int ZERO_BIT = 9,
  parameter int ONE_BIT  = 6,
  parameter int RST_LAT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] word,
  output logic              err
);

  // Forces the bits that have a fixed read value.
  function automatic logic [ADDR_W-1:0] pin_fixed(input logic [ADDR_W-1:0] w);
    logic [ADDR_W-1:0] r;
    r = w;
    r[SEL_BIT]  = 1'b1;
    r[ZERO_BIT] = 1'b0;
    r[ONE_BIT]  = 1'b1;
    return r;
  endfunction

  localparam logic [ADDR_W-1:0] RST_WORD =
    pin_fixed((ADDR_W'(1) << OPM_BIT) | (ADDR_W'(RST_LAT) << LAT_LSB));

  logic [ADDR_W-1:0] word_q;
  logic [ADDR_W-1:0] word_nxt;
  logic              err_q;
  logic              code_ok;

  always_comb begin
    code_ok  = lat_code_ok(wr_data[LAT_LSB +: LAT_W]);
    word_nxt = pin_fixed(wr_data);
    if (!code_ok) word_nxt[LAT_LSB +: LAT_W] = word_q[LAT_LSB +: LAT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= RST_WORD;
      err_q  <= 1'b0;
    end else if (wr_en) begin
      word_q <= word_nxt;
      if (!code_ok) err_q <= 1'b1;
    end
  end

  assign word = word_q;
  assign err  = err_q;

  // R2: without an accepted command the word keeps its value
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(word_q));

  // R5: the stored latency code is always one of the legal codes
  a_r5_lat_legal: assert property (@(posedge clk) disable iff (!rst_n)
    lat_code_ok(word_q[LAT_LSB +: LAT_W]));

  // R6: a reserved code keeps the old latency and raises the flag
  a_r6_reserved_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lat_code_ok(wr_data[LAT_LSB +: LAT_W]))
      |=> ($stable(word_q[LAT_LSB +: LAT_W]) && err_q));

  // R6: the error flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: rtl/burst_lat_timer.sv
module burst_lat_timer
  import burst_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [LAT_W-1:0] lat,
  output logic             pulse
);

  logic [LAT_W-1:0] cnt_q;
  logic             pulse_q;
  logic             last_tick;

  assign last_tick = (cnt_q == LAT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (abort) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (start) begin
      cnt_q   <= lat;
      pulse_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - LAT_W'(1);
      pulse_q <= last_tick;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse = pulse_q;

  // R7: the first-beat pulse lasts a single cycle
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R8: ending the access clears any pending beat
  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!pulse_q && cnt_q == '0));

endmodule

// File: rtl/burst_wr_detect.sv
module burst_wr_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_sel,
  input  logic wr_sel,
  input  logic cfg_sel,
  input  logic addr_vld,
  input  logic async_mode,
  output logic wsync
);

  logic seen_q;
  logic ws_q;
  logic wr_cyc;

  assign wr_cyc = chip_sel && wr_sel && !cfg_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      ws_q   <= 1'b0;
    end else begin
      if (!chip_sel) seen_q <= 1'b0;
      else if (wr_cyc && addr_vld && !async_mode) seen_q <= 1'b1;

      if (async_mode) ws_q <= 1'b0;
      else if (wr_cyc) begin
        if (addr_vld) ws_q <= 1'b1;
        else if (!seen_q) ws_q <= 1'b0;
      end
    end
  end

  assign wsync = ws_q;

  // R10: a clock edge inside the strobe window marks the write synchronous
  a_r10_edge_marks_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && addr_vld && !async_mode) |=> ws_q);

  // R11: asynchronous mode holds the write flag low
  a_r11_async_no_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $past(async_mode) |-> !ws_q);

endmodule

// File: rtl/burst_cfg_ctrl.sv
module burst_cfg_ctrl
  import burst_cfg_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int SEL_BIT = 19,
  parameter int OPM_BIT = 15,
  parameter int LAT_LSB = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel,
  input  logic              addr_vld,
  input  logic              wr_sel,
  input  logic              out_en,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [1:0]        op_mode,
  output logic [LAT_W-1:0]  rd_latency,
  output logic              first_beat,
  output logic              wr_is_sync,
  output logic [ADDR_W-1:0] cfg_word,
  output logic              cfg_err
);

  logic [ADDR_W-1:0] word_w;
  logic              err_w;
  logic              busy_q;
  logic              cfg_cmd;
  logic              cfg_accept;
  logic              async_mode;
  logic              rd_start;
  logic              acc_end;
  logic              beat_q;
  logic              ws_w;

  // Access tracking: busy from a strobed access until the chip is deselected.
  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else if (!chip_sel) busy_q <= 1'b0;
    else if (addr_vld && !cfg_sel) busy_q <= 1'b1;
  end

  assign cfg_cmd    = chip_sel && cfg_sel && wr_sel && addr_vld && addr_in[SEL_BIT];
  assign cfg_accept = cfg_cmd && !busy_q;
  assign async_mode = word_w[OPM_BIT];
  assign rd_start   = chip_sel && addr_vld && !wr_sel && !cfg_sel && !async_mode;
  assign acc_end    = !chip_sel;

  burst_cfg_reg #(
    .ADDR_W (ADDR_W),
    .SEL_BIT(SEL_BIT),
    .OPM_BIT(OPM_BIT),
    .LAT_LSB(LAT_LSB)
  ) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_accept),
    .wr_data(addr_in),
    .word   (word_w),
    .err    (err_w)
  );

  burst_lat_timer u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(rd_start),
    .abort(acc_end),
    .lat  (word_w[LAT_LSB +: LAT_W]),
    .pulse(beat_q)
  );

  burst_wr_detect u_wdet (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_sel  (chip_sel),
    .wr_sel    (wr_sel),
    .cfg_sel   (cfg_sel),
    .addr_vld  (addr_vld),
    .async_mode(async_mode),
    .wsync     (ws_w)
  );

  assign op_mode    = 2'(decode_mode(async_mode, ws_w));
  assign rd_latency = word_w[LAT_LSB +: LAT_W];
  assign first_beat = beat_q && out_en;
  assign wr_is_sync = ws_w;
  assign cfg_word   = word_w;
  assign cfg_err    = err_w;

  // R9: the word cannot change while an access is in progress
  a_r9_locked_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(word_w));

  // R11: no first-beat pulse in asynchronous mode
  a_r11_no_beat_async: assert property (@(posedge clk) disable iff (!rst_n)
    async_mode |-> !beat_q);

  // R4: the mode output never takes the unused encoding
  a_r4_mode_encoding: assert property (@(posedge clk) disable iff (!rst_n)
    op_mode != 2'd3);

endmodule

// File: tb/burst_cfg_ctrl_tb.sv
module burst_cfg_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_sel = 1'b0, addr_vld = 1'b0, wr_sel = 1'b0, out_en = 1'b0, cfg_sel = 1'b0;
  logic [20:0] addr_in = '0;
  logic [1:0]  op_mode;
  logic [2:0]  rd_latency;
  logic        first_beat, wr_is_sync, cfg_err;
  logic [20:0] cfg_word;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int exp_q[$];
  string cur_tag = "R7";
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  burst_cfg_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .addr_vld(addr_vld),
    .wr_sel(wr_sel), .out_en(out_en), .cfg_sel(cfg_sel), .addr_in(addr_in),
    .op_mode(op_mode), .rd_latency(rd_latency), .first_beat(first_beat),
    .wr_is_sync(wr_is_sync), .cfg_word(cfg_word), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected first-beat cycles, flags any stray pulse.
  always @(negedge clk) begin
    if (rst_n) begin
      logic e;
      e = (exp_q.size() > 0) && (exp_q[0] == cyc);
      if (e) void'(exp_q.pop_front());
      if (e || first_beat) chk({cur_tag, " first_beat"}, 32'(first_beat), 32'(e));
    end
  end

  task automatic all_low();
    chip_sel = 0; addr_vld = 0; wr_sel = 0; out_en = 0; cfg_sel = 0;
  endtask

  task automatic cfg_write(input logic [20:0] d);
    @(negedge clk);
    chip_sel = 1; cfg_sel = 1; wr_sel = 1; addr_vld = 1; addr_in = d;
    @(negedge clk);
    all_low();
    @(negedge clk);
  endtask

  // Read burst; pushes expected pulse cycle when one is due.
  task automatic read_burst(input int hold, input bit expect_beat, input int lat);
    @(negedge clk);
    chip_sel = 1; addr_vld = 1; wr_sel = 0; cfg_sel = 0; out_en = 1;
    if (expect_beat) exp_q.push_back(cyc + 1 + lat);
    @(negedge clk);
    addr_vld = 0;
    repeat (hold - 1) @(negedge clk);
    all_low();
    repeat (2) @(negedge clk);
  endtask

  task automatic write_access(input bit strobe_on_edge);
    @(negedge clk);
    chip_sel = 1; wr_sel = 1; addr_vld = strobe_on_edge;
    @(negedge clk);
    addr_vld = 0;
    @(negedge clk);
    all_low();
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cfg_word", 32'(cfg_word), 32'h89840);
    chk("R1 op_mode", 32'(op_mode), 0);
    chk("R1 rd_latency", 32'(rd_latency), 3);
    chk("R1 cfg_err", 32'(cfg_err), 0);
    chk("R1 wr_is_sync", 32'(wr_is_sync), 0);

    cur_tag = "R11";
    read_burst(6, 0, 3);
    write_access(1);
    chk("R11 wr_is_sync async", 32'(wr_is_sync), 0);

    cur_tag = "R7";
    cfg_write(21'h81200);
    chk("R2 R3 cfg_word", 32'(cfg_word), 32'h81040);
    chk("R4 op_mode sync read", 32'(op_mode), 1);
    chk("R5 rd_latency 2", 32'(rd_latency), 2);
    read_burst(5, 1, 2);

    write_access(1);
    chk("R10 sync write flag", 32'(wr_is_sync), 1);
    chk("R4 op_mode full sync", 32'(op_mode), 2);
    write_access(0);
    chk("R10 async write flag", 32'(wr_is_sync), 0);
    chk("R4 op_mode after async write", 32'(op_mode), 1);

    cfg_write(21'h01800);
    chk("R2 other register ignored", 32'(cfg_word), 32'h81040);

    cfg_write(21'h81800);
    chk("R5 rd_latency 3", 32'(rd_latency), 3);
    chk("R2 cfg_word lat3", 32'(cfg_word), 32'h81840);
    read_burst(6, 1, 3);

    cfg_write(21'h83800);
    chk("R6 latency kept", 32'(rd_latency), 3);
    chk("R6 cfg_word", 32'(cfg_word), 32'h81840);
    chk("R6 cfg_err set", 32'(cfg_err), 1);

    // R9: command during an active burst is dropped
    cur_tag = "R9";
    @(negedge clk);
    chip_sel = 1; addr_vld = 1; out_en = 1;
    exp_q.push_back(cyc + 1 + 3);
    @(negedge clk);
    addr_vld = 0;
    @(negedge clk);
    cfg_sel = 1; wr_sel = 1; addr_vld = 1; addr_in = 21'h89000;
    @(negedge clk);
    cfg_sel = 0; wr_sel = 0; addr_vld = 0;
    repeat (4) @(negedge clk);
    all_low();
    repeat (2) @(negedge clk);
    chk("R9 cfg_word unchanged", 32'(cfg_word), 32'h81840);

    cur_tag = "R8";
    read_burst(1, 0, 3);
    chk("R8 no pending beat", 32'(exp_q.size()), 0);

    // R7: out_en low gates the pulse
    cur_tag = "R7 out_en";
    @(negedge clk);
    chip_sel = 1; addr_vld = 1; out_en = 0;
    @(negedge clk);
    addr_vld = 0;
    repeat (6) @(negedge clk);
    all_low();
    repeat (2) @(negedge clk);

    cur_tag = "R11";
    cfg_write(21'h89840);
    chk("R11 op_mode async", 32'(op_mode), 0);
    chk("R6 cfg_err sticky", 32'(cfg_err), 1);
    read_burst(6, 0, 3);
    write_access(1);
    chk("R11 write flag held", 32'(wr_is_sync), 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule